// File: doc/BRIEF.md
# UART Status and Interrupt Controller

This block is the register front end of a simple serial port. It holds eight 16-bit control words, two status words whose bits are set by event strobes from the receive and transmit datapaths, and a read-only test-status word. The masked status bits are merged into one level-sensitive interrupt line. Software reads and writes the registers through a small synchronous bus port. Read data is registered and returned one cycle after the request.

Writing a one to a status bit clears it, and a hardware event always wins over a clear in the same cycle. The block also manages a transmit holding path that takes one byte at a time. A write to the transmit data offset launches a byte toward the serializer as a one-cycle strobe, and the transmit-ready flags stay low until the serializer reports that it is done.

Register map (byte offsets, 4-byte stride): 0x00 transmit data (write only, reads 0), 0x04 control A, 0x08 control B, 0x0C control C, 0x10 control D, 0x14 FIFO control, 0x18 baud modulator, 0x1C baud count, 0x20 millisecond tick, 0x24 status A, 0x28 status B, 0x2C test status. Status A bits: 0 tx-ready, 1 rx-ready, 2 age-timeout, 3 rx-idle, 4 RTS-state. Status B bits: 0 data-ready, 1 overrun, 2 tx-complete, 3 tx-FIFO-empty, 4 wake, 5 DCD-in, 6 break. Control B bits: 0 soft-reset flag, 2 transmit enable, 3 age interrupt enable. Test status bits: 0 rx-empty, 1 tx-empty.

Top module: `uart_stat_irq_ctl`

## Requirements
- R1: After reset, control B reads 0x0001, control C 0x0700, baud count 0x0004, status A 0x0019, status B 0x002C and test status 0x0003. Every other offset reads 0.
- R2: A write to any control, FIFO-control, baud or tick word stores the low 16 bits of the write data. Bits 31..16 read back as zero.
- R3: Read data appears on bus_rdata in the cycle after the request. Unaligned offsets, undefined offsets (0x30 and above) and the transmit data offset read 0. Writes to undefined offsets change no register.
- R4: Writing a one to a bit of status A (0x24) or status B (0x28) clears that bit. Bits written with zero keep their value.
- R5: An event input sets its status bit one cycle later: ev_rx_ready sets A1, ev_age sets A2, ev_data_ready sets B0, ev_overrun sets B1, ev_wake sets B4 and ev_break sets B6. If the event arrives in the same cycle as a clear of that bit, the bit ends up set.
- R6: Status A bits 0 (tx-ready) and 1 (rx-ready) drive irq only while control A bit 0 and bit 1, respectively, are set.
- R7: Status A bit 2 (age-timeout) drives irq only while control B bit 3 is set.
- R8: Status B bit 3 (tx-FIFO-empty) drives irq only while control A bit 6 is set.
- R9: Status B bits 0, 1, 2 and 4 each drive irq only while the control D bit at the same position is set.
- R10: irq is the OR of all enabled sources. Break, rx-idle, RTS-state and DCD-in never drive irq.
- R11: A write to 0x00 while control B bit 2 is set and no byte is pending raises tx_valid for exactly one cycle, on the next cycle, with the low data byte on tx_byte. It also clears status A0 and status B2 and B3, and test-status bit 1.
- R12: A write to 0x00 while transmit enable is clear, or while a byte is still pending, produces no strobe and leaves the status unchanged.
- R13: tx_done while a byte is pending sets status A0, B2 and B3, and test-status bit 1, one cycle later.
- R14: Test-status bit 0 reads as the inverse of status B bit 0 (data-ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| ev_rx_ready | input | 1 | Receive threshold reached strobe |
| ev_data_ready | input | 1 | Receive data present strobe |
| ev_overrun | input | 1 | Receive overrun strobe |
| ev_age | input | 1 | Receive ageing timeout strobe |
| ev_wake | input | 1 | Wake detected strobe |
| ev_break | input | 1 | Break detected strobe |
| tx_valid | output | 1 | One-cycle byte hand-off to the serializer |
| tx_byte | output | 8 | Byte handed off |
| tx_done | input | 1 | Serializer finished the pending byte |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, event strobes and tx_done take effect at the clock edge that samples them. irq is combinational from the registers, so it is valid in that same cycle. tx_valid is registered and is high for the single cycle that follows an accepted write. Read data is due one cycle after the request. The bench drives inputs on the falling edge and samples outputs on the next falling edge, half a cycle after the edge that updates them. Each enable is swept on and off, one interrupt source at a time, and every status result is confirmed through a bus read.

// File: rtl/uart_csr_pkg.sv
// Shared constants for the UART status/interrupt register block.
// Assumes: 16-bit registers on a 4-byte address stride.
package uart_csr_pkg;
    localparam int REG_W    = 16;
    localparam int NUM_CTRL = 8;
    localparam int CIDX_W   = $clog2(NUM_CTRL);

    // word indices (byte offset / 4)
    localparam int W_TXDATA    = 0;
    localparam int W_CTRL_BASE = 1;
    localparam int W_STAT_A    = W_CTRL_BASE + NUM_CTRL;
    localparam int W_STAT_B    = W_STAT_A + 1;
    localparam int W_TSTAT     = W_STAT_B + 1;

    // control bank slots
    localparam int CW_A    = 0;
    localparam int CW_B    = 1;
    localparam int CW_C    = 2;
    localparam int CW_D    = 3;
    localparam int CW_FIFO = 4;
    localparam int CW_BMOD = 5;
    localparam int CW_BCNT = 6;
    localparam int CW_TICK = 7;

    // status A bits; control A enables share bits 0 and 1
    localparam int SA_TXRDY  = 0;
    localparam int SA_RXRDY  = 1;
    localparam int SA_AGE    = 2;
    localparam int SA_RXIDLE = 3;
    localparam int SA_RTS    = 4;
    localparam int CA_TXFE_IE = 6;

    // control B bits
    localparam int CB_SRST   = 0;
    localparam int CB_TXEN   = 2;
    localparam int CB_AGE_IE = 3;

    // status B bits; control D enables share positions
    localparam int SB_RDR   = 0;
    localparam int SB_ORE   = 1;
    localparam int SB_TXDC  = 2;
    localparam int SB_TXFE  = 3;
    localparam int SB_WAKE  = 4;
    localparam int SB_DCD   = 5;
    localparam int SB_BRK   = 6;

    localparam logic [REG_W-1:0] SA_IRQ_MASK = REG_W'((1 << SA_TXRDY) | (1 << SA_RXRDY));
    localparam logic [REG_W-1:0] SB_IRQ_MASK =
        REG_W'((1 << SB_RDR) | (1 << SB_ORE) | (1 << SB_TXDC) | (1 << SB_WAKE));

    localparam logic [REG_W-1:0] STAT_A_RST =
        REG_W'((1 << SA_TXRDY) | (1 << SA_RXIDLE) | (1 << SA_RTS));
    localparam logic [REG_W-1:0] STAT_B_RST =
        REG_W'((1 << SB_TXDC) | (1 << SB_TXFE) | (1 << SB_DCD));

    // reset value of each control bank slot
    function automatic logic [REG_W-1:0] ctrl_reset_value(input int slot);
        case (slot)
            CW_B:    return REG_W'(1 << CB_SRST);
            CW_C:    return REG_W'(16'h0700);
            CW_BCNT: return REG_W'(4);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/uart_csr_ctrl_bank.sv
// Control bank: NUM_W plain read/write words of REG_W bits each.
// Assumes: wr_en and wr_idx are already decoded and aligned by the parent.
module uart_csr_ctrl_bank
    import uart_csr_pkg::*;
#(
    parameter int NUM_W = NUM_CTRL,
    parameter int IDX_W = CIDX_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [REG_W-1:0]             wr_data,
    output logic [NUM_W-1:0][REG_W-1:0]  ctrl_q
);
    for (genvar g = 0; g < NUM_W; g++) begin : g_word
        // hold one control word; load it on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctrl_q[g] <= ctrl_reset_value(g);
            else if (wr_en && wr_idx == IDX_W'(g))
                ctrl_q[g] <= wr_data;
        end

        // R2
        low_half_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_idx == IDX_W'(g)) |=> (ctrl_q[g] == $past(wr_data)));
    end
endmodule

// File: rtl/uart_csr_status.sv
// Status words A and B with write-one-to-clear and event set, plus the
// single-byte transmit holding handshake.
// Assumes: events are one-cycle strobes; tx_done only matters while busy.
module uart_csr_status
    import uart_csr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  w1c_a,
    input  logic [REG_W-1:0]  w1c_b,
    input  logic              ev_rx_ready,
    input  logic              ev_data_ready,
    input  logic              ev_overrun,
    input  logic              ev_age,
    input  logic              ev_wake,
    input  logic              ev_break,
    input  logic              txd_wr,
    input  logic [BYTE_W-1:0] txd_byte,
    input  logic              tx_en,
    input  logic              tx_done,
    output logic [REG_W-1:0]  stat_a,
    output logic [REG_W-1:0]  stat_b,
    output logic              tx_busy,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);
    logic             tx_accept;
    logic             tx_finish;
    logic [REG_W-1:0] set_a, set_b, hwclr_a, hwclr_b;

    // decide transmit acceptance and completion
    always_comb begin
        tx_accept = txd_wr && tx_en && !tx_busy;
        tx_finish = tx_done && tx_busy;
    end

    // gather hardware set and clear vectors for both status words
    always_comb begin
        set_a   = '0;
        set_b   = '0;
        hwclr_a = '0;
        hwclr_b = '0;
        set_a[SA_RXRDY] = ev_rx_ready;
        set_a[SA_AGE]   = ev_age;
        set_a[SA_TXRDY] = tx_finish;
        set_b[SB_RDR]   = ev_data_ready;
        set_b[SB_ORE]   = ev_overrun;
        set_b[SB_WAKE]  = ev_wake;
        set_b[SB_BRK]   = ev_break;
        set_b[SB_TXDC]  = tx_finish;
        set_b[SB_TXFE]  = tx_finish;
        hwclr_a[SA_TXRDY] = tx_accept;
        hwclr_b[SB_TXDC]  = tx_accept;
        hwclr_b[SB_TXFE]  = tx_accept;
    end

    // update status words: clears first, sets win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_a <= STAT_A_RST;
            stat_b <= STAT_B_RST;
        end else begin
            stat_a <= (stat_a & ~(w1c_a | hwclr_a)) | set_a;
            stat_b <= (stat_b & ~(w1c_b | hwclr_b)) | set_b;
        end
    end

    // track the pending byte and issue the hand-off strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_busy  <= 1'b0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= tx_accept;
            if (tx_accept) begin
                tx_busy <= 1'b1;
                tx_byte <= txd_byte;
            end else if (tx_finish) begin
                tx_busy <= 1'b0;
            end
        end
    end

    // R11
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_accept |=> (tx_valid && tx_busy && !stat_a[SA_TXRDY] && !stat_b[SB_TXDC]));
    // R13
    finish_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_finish |=> (!tx_busy && stat_a[SA_TXRDY] && stat_b[SB_TXDC] && stat_b[SB_TXFE]));
    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_b == '0) |=> ((stat_b & $past(w1c_b)) == '0));
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_a != '0) |=> ((stat_a & $past(set_a)) == $past(set_a)));
    // R12
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);
endmodule

// File: rtl/uart_csr_irq_merge.sv
// Interrupt merge: masks both status words with their enables and ORs them.
// Assumes: inputs are registered; the output is a combinational level.
module uart_csr_irq_merge
    import uart_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stat_a,
    input  logic [REG_W-1:0] stat_b,
    input  logic [REG_W-1:0] ctrl_a,
    input  logic [REG_W-1:0] ctrl_b,
    input  logic [REG_W-1:0] ctrl_d,
    output logic             irq
);
    logic src_a, src_age, src_txfe, src_b;
    logic unused_ctrl_b;

    // combine aligned masks and the two gated sources
    always_comb begin
        src_a    = |(stat_a & ctrl_a & SA_IRQ_MASK);
        src_age  = ctrl_b[CB_AGE_IE] && stat_a[SA_AGE];
        src_txfe = ctrl_a[CA_TXFE_IE] && stat_b[SB_TXFE];
        src_b    = |(stat_b & ctrl_d & SB_IRQ_MASK);
        irq      = src_a || src_age || src_txfe || src_b;
    end

    assign unused_ctrl_b = ^ctrl_b;

    // R10
    quiet_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_a == '0 && ctrl_d == '0 && !ctrl_b[CB_AGE_IE]) |-> !irq);
endmodule

// File: rtl/uart_stat_irq_ctl.sv
// Top: register decode, read mux, control bank, status words and interrupt.
// Assumes: one access per cycle; read data registered, one cycle latency.
module uart_stat_irq_ctl
    import uart_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_rx_ready,
    input  logic              ev_data_ready,
    input  logic              ev_overrun,
    input  logic              ev_age,
    input  logic              ev_wake,
    input  logic              ev_break,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    input  logic              tx_done,
    output logic              irq
);
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] IX_TXD  = WORD_W'(W_TXDATA);
    localparam logic [WORD_W-1:0] IX_CLO  = WORD_W'(W_CTRL_BASE);
    localparam logic [WORD_W-1:0] IX_CHI  = WORD_W'(W_CTRL_BASE + NUM_CTRL - 1);
    localparam logic [WORD_W-1:0] IX_SA   = WORD_W'(W_STAT_A);
    localparam logic [WORD_W-1:0] IX_SB   = WORD_W'(W_STAT_B);
    localparam logic [WORD_W-1:0] IX_TST  = WORD_W'(W_TSTAT);

    logic [WORD_W-1:0]               word;
    logic                            aligned, wr, rd, ctrl_hit;
    logic [CIDX_W-1:0]               ctrl_idx;
    logic [NUM_CTRL-1:0][REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]                w1c_a, w1c_b, stat_a, stat_b, tstat, rd_word;
    logic                            tx_busy;
    logic                            unused_wdata_hi;

    // decode the access
    always_comb begin
        word     = bus_addr[ADDR_W-1:2];
        aligned  = (bus_addr[1:0] == 2'b00);
        wr       = bus_sel && bus_we && aligned;
        rd       = bus_sel && !bus_we;
        ctrl_hit = (word >= IX_CLO) && (word <= IX_CHI);
        ctrl_idx = CIDX_W'(word - IX_CLO);
        w1c_a    = (wr && word == IX_SA) ? bus_wdata[REG_W-1:0] : '0;
        w1c_b    = (wr && word == IX_SB) ? bus_wdata[REG_W-1:0] : '0;
    end

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];

    uart_csr_ctrl_bank #(.NUM_W(NUM_CTRL), .IDX_W(CIDX_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr && ctrl_hit),
        .wr_idx  (ctrl_idx),
        .wr_data (bus_wdata[REG_W-1:0]),
        .ctrl_q  (ctrl_q)
    );

    uart_csr_status #(.BYTE_W(BYTE_W)) stat_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .w1c_a         (w1c_a),
        .w1c_b         (w1c_b),
        .ev_rx_ready   (ev_rx_ready),
        .ev_data_ready (ev_data_ready),
        .ev_overrun    (ev_overrun),
        .ev_age        (ev_age),
        .ev_wake       (ev_wake),
        .ev_break      (ev_break),
        .txd_wr        (wr && word == IX_TXD),
        .txd_byte      (bus_wdata[BYTE_W-1:0]),
        .tx_en         (ctrl_q[CW_B][CB_TXEN]),
        .tx_done       (tx_done),
        .stat_a        (stat_a),
        .stat_b        (stat_b),
        .tx_busy       (tx_busy),
        .tx_valid      (tx_valid),
        .tx_byte       (tx_byte)
    );

    uart_csr_irq_merge irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_a (stat_a),
        .stat_b (stat_b),
        .ctrl_a (ctrl_q[CW_A]),
        .ctrl_b (ctrl_q[CW_B]),
        .ctrl_d (ctrl_q[CW_D]),
        .irq    (irq)
    );

    // build test status and select the word to read
    always_comb begin
        tstat    = '0;
        tstat[0] = !stat_b[SB_RDR];
        tstat[1] = !tx_busy;
        rd_word  = '0;
        if (aligned) begin
            if (ctrl_hit)            rd_word = ctrl_q[ctrl_idx];
            else if (word == IX_SA)  rd_word = stat_a;
            else if (word == IX_SB)  rd_word = stat_b;
            else if (word == IX_TST) rd_word = tstat;
        end
    end

    // register read data, zero-extended
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd)
            bus_rdata <= DATA_W'(rd_word);
        else
            bus_rdata <= '0;
    end

    // R11
    tx_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bus_sel && bus_we && bus_addr == '0));
endmodule

// File: tb/uart_stat_irq_ctl_tb.sv
module uart_stat_irq_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic ev_rx_ready = 0, ev_data_ready = 0, ev_overrun = 0, ev_age = 0, ev_wake = 0, ev_break = 0;
    logic        tx_valid, tx_done = 0, irq;
    logic [7:0]  tx_byte;
    int          checks = 0, errors = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    uart_stat_irq_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx_ready(ev_rx_ready), .ev_data_ready(ev_data_ready),
        .ev_overrun(ev_overrun), .ev_age(ev_age), .ev_wake(ev_wake),
        .ev_break(ev_break), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_done(tx_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 0;
    endtask

    // id: 0 rx_ready 1 data_ready 2 overrun 3 age 4 wake 5 break 6 tx_done
    task automatic pulse(input int id);
        @(negedge clk);
        case (id)
            0: ev_rx_ready = 1;  1: ev_data_ready = 1; 2: ev_overrun = 1;
            3: ev_age = 1;       4: ev_wake = 1;       5: ev_break = 1;
            default: tx_done = 1;
        endcase
        @(negedge clk);
        {ev_rx_ready, ev_data_ready, ev_overrun, ev_age, ev_wake, ev_break, tx_done} = '0;
    endtask

    function automatic logic [31:0] reset_val(input int w);
        case (w)
            2: return 32'h0001;  3: return 32'h0700;  7: return 32'h0004;
            9: return 32'h0019; 10: return 32'h002C; 11: return 32'h0003;
            default: return 32'h0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 irq after reset", {31'b0, irq}, 0);
        for (int w = 0; w < 16; w++) begin
            rd(6'(w * 4), rv);
            chk($sformatf("R1 reset word %0d", w), rv, reset_val(w));
        end
        rd(6'h09, rv);
        chk("R3 unaligned read", rv, 0);

        // control sweep: low 16 bits kept
        for (int w = 1; w <= 8; w++) wr(6'(w * 4), 32'hBEEF_0000 | 32'((w * 16'h1111) ^ 16'h5A5A));
        for (int w = 12; w < 16; w++) wr(6'(w * 4), 32'hFFFF_FFFF);
        for (int w = 1; w <= 8; w++) begin
            rd(6'(w * 4), rv);
            chk($sformatf("R2 ctrl word %0d", w), rv, 32'((w * 16'h1111) ^ 16'h5A5A));
        end
        for (int w = 12; w < 16; w++) begin
            rd(6'(w * 4), rv);
            chk($sformatf("R3 undefined word %0d", w), rv, 0);
        end
        rd(6'h00, rv);
        chk("R3 txdata reads zero", rv, 0);
        for (int w = 1; w <= 8; w++) wr(6'(w * 4), 0);

        // transmit path
        wr(6'h00, 32'h5A);
        chk("R12 no strobe without enable", {31'b0, tx_valid}, 0);
        rd(6'h24, rv);
        chk("R12 tx-ready kept", rv & 1, 1);
        wr(6'h08, 32'h4);
        wr(6'h00, 32'hFFC3);
        chk("R11 strobe", {31'b0, tx_valid}, 1);
        chk("R11 byte", {24'b0, tx_byte}, 32'hC3);
        @(negedge clk);
        chk("R11 strobe one cycle", {31'b0, tx_valid}, 0);
        rd(6'h24, rv); chk("R11 tx-ready cleared", rv & 1, 0);
        rd(6'h28, rv); chk("R11 txdc/txfe cleared", rv & 32'hC, 0);
        rd(6'h2C, rv); chk("R11 tx-empty cleared", rv & 2, 0);
        wr(6'h00, 32'h11);
        chk("R12 no strobe while busy", {31'b0, tx_valid}, 0);
        pulse(6);
        rd(6'h24, rv); chk("R13 tx-ready set", rv & 1, 1);
        rd(6'h28, rv); chk("R13 txdc/txfe set", rv & 32'hC, 32'hC);
        rd(6'h2C, rv); chk("R13 tx-empty set", rv & 2, 2);

        // data-ready and test status
        pulse(1);
        rd(6'h2C, rv); chk("R14 rx-empty low", rv & 1, 0);
        wr(6'h28, 32'h1);
        rd(6'h2C, rv); chk("R14 rx-empty high", rv & 1, 1);

        // set beats clear in the same cycle
        @(negedge clk);
        ev_overrun = 1; bus_sel = 1; bus_we = 1; bus_addr = 6'h28; bus_wdata = 32'h2;
        @(negedge clk);
        ev_overrun = 0; bus_sel = 0; bus_we = 0;
        rd(6'h28, rv); chk("R5 set wins over clear", rv & 2, 2);

        // partial clear
        pulse(4); pulse(5);
        wr(6'h28, 32'h40);
        rd(6'h28, rv); chk("R4 partial clear", rv & 32'h50, 32'h10);

        // interrupt sweep: sources 0 txrdy 1 rxrdy 2 age 3 txfe 4 txdc 5 rdr 6 ore 7 wake
        for (int s = 0; s < 8; s++) begin
            for (int en = 0; en < 2; en++) begin
                logic [31:0] ca, cb, cd, clr;
                logic [5:0]  sa;
                string tag;
                wr(6'h04, 0); wr(6'h10, 0); wr(6'h08, 32'h4);
                wr(6'h24, 32'hFFFF); wr(6'h28, 32'hFFFF);
                chk("R10 idle irq", {31'b0, irq}, 0);
                ca = 0; cb = 32'h4; cd = 0;
                case (s)
                    0: begin wr(6'h00, 32'h40); pulse(6); ca = 32'h1;  sa = 6'h24; clr = 32'h1; tag = "R6 txrdy"; end
                    1: begin pulse(0);          ca = 32'h2;  sa = 6'h24; clr = 32'h2; tag = "R6 rxrdy"; end
                    2: begin pulse(3);          cb = 32'hC;  sa = 6'h24; clr = 32'h4; tag = "R7 age"; end
                    3: begin wr(6'h00, 32'h43); pulse(6); ca = 32'h40; sa = 6'h28; clr = 32'h8; tag = "R8 txfe"; end
                    4: begin wr(6'h00, 32'h44); pulse(6); cd = 32'h4;  sa = 6'h28; clr = 32'h4; tag = "R9 txdc"; end
                    5: begin pulse(1);          cd = 32'h1;  sa = 6'h28; clr = 32'h1; tag = "R9 rdr"; end
                    6: begin pulse(2);          cd = 32'h2;  sa = 6'h28; clr = 32'h2; tag = "R9 ore"; end
                    default: begin pulse(4);    cd = 32'h10; sa = 6'h28; clr = 32'h10; tag = "R9 wake"; end
                endcase
                if (en == 1) begin wr(6'h04, ca); wr(6'h08, cb); wr(6'h10, cd); end
                chk($sformatf("%s en=%0d", tag, en), {31'b0, irq}, 32'(en));
                if (en == 1) begin
                    wr(sa, clr);
                    chk($sformatf("R4 %s cleared", tag), {31'b0, irq}, 0);
                end
            end
        end

        // break and hold-over bits never interrupt
        wr(6'h24, 32'hFFFF); wr(6'h28, 32'hFFFF);
        wr(6'h04, 32'hFFFF); wr(6'h08, 32'h0C); wr(6'h10, 32'hFFFF);
        pulse(5);
        chk("R10 break no irq", {31'b0, irq}, 0);
        rd(6'h28, rv); chk("R5 break set", rv & 32'h40, 32'h40);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule